// File: doc/BRIEF.md
# Frame Rate Change Watchdog

This block monitors an audio frame (word-select) clock against a faster free-running reference clock. The frame clock is synchronised into the reference domain. The block counts reference cycles between consecutive rising frame edges and compares each period with a baseline learned from the first complete period. A run of eight consecutive periods that sit more than one sixteenth away from the baseline makes the block issue a one-cycle internal reset, drop the baseline and learn it again. A frame clock that stops issues the same reset.

From power-up and after every internal reset, the block holds a force-low flag that the surrounding converter uses to drive its serial data output low. The flag stays set until recovery ends, which happens once 162 frames have been counted on the input frame clock and 162 strobes on the other port's frame strobe. Recovery therefore lasts 162 periods of whichever of the two rates is slower. When the flag clears, the valid output rises. All of these pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake and no back-pressure apply.

Top module: `frame_rate_watch`

## Requirements
- R1: After power-down release and after every internal reset, the first complete rising-to-rising frame period is stored as the baseline. `redetect` is 1 while no baseline is held and 0 once one is stored. The stored baseline does not change while one is held.
- R2: A period is deviating only when |period - baseline| > baseline >> 4. With a baseline of 64 cycles, a period of 68 is within tolerance and a period of 80 is deviating.
- R3: Eight consecutive deviating periods produce a one-cycle pulse on `int_reset`. A run of seven, or any run broken by a period within tolerance, produces no pulse, and the run count restarts from zero.
- R4: When no rising frame edge arrives for 4 × baseline reference cycles, `int_reset` pulses once. Without a baseline, the limit is `NOBASE_WAIT` cycles. No further pulse follows until frame edges return.
- R5: An internal reset discards the baseline, sets `force_low` to 1 and clears `valid` from the next cycle.
- R6: Recovery ends only after 162 rising frame edges and 162 `out_strobe` pulses have both been counted since the last reset. `force_low` then falls and `valid` rises.
- R7: While `pdn_n` is 0, the block is held cleared: `int_reset`=0, `redetect`=1, `force_low`=1, `valid`=0. Recovery starts afresh after release.
- R8: The slower strobe governs recovery. With no `out_strobe` pulses, `force_low` stays 1 however many input frames arrive.
- R9: `frame_in` passes through a two-flop synchroniser, and every period is measured from rising edge to rising edge in reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| pdn_n | input | 1 | Active-low power-down; asynchronous clear of the whole block |
| frame_in | input | 1 | Input-port frame clock, asynchronous to clk_ref |
| out_strobe | input | 1 | One-cycle pulse per output-port frame, synchronous to clk_ref |
| int_reset | output | 1 | One-cycle internal reset pulse |
| redetect | output | 1 | High while the rate baseline is being learned again |
| force_low | output | 1 | Force the serial data output low |
| valid | output | 1 | Output data is valid; recovery has ended |

## Verification
Every cycle, the assertions check the following: a stop timeout is followed by an internal reset, the deviation run never reaches its limit without firing, a held baseline stays unchanged, a reset drops the baseline and raises force-low, and force-low falls only when both frame counts have reached 162. Only the bench scenarios can show the tolerance boundary at 1/16, the difference between seven and eight deviating frames, the length of the stop timeout, and the way a missing output strobe keeps recovery open.

// File: rtl/frw_pkg.sv
package frw_pkg;
  typedef enum logic {PH_RECOVER = 1'b0, PH_RUN = 1'b1} phase_e;
endpackage

// File: rtl/frw_sync.sv
module frw_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= 3'b000;
    else        sh <= {sh[1:0], async_in};
  end
  // sh[1] is the second synchroniser stage (R9); sh[2] is its delayed copy
  assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/frw_period_meter.sv
module frw_period_meter #(
  parameter int CNT_W       = 16,
  parameter int NOBASE_WAIT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             restart,
  input  logic             base_ok,
  input  logic [CNT_W-1:0] baseline,
  output logic             per_done,
  output logic [CNT_W-1:0] per_val,
  output logic             stop_pulse
);
  localparam int LW = CNT_W + 2;

  logic [CNT_W-1:0] cnt;
  logic             armed, stalled;
  logic [LW-1:0]    limit;
  logic             at_limit;

  assign limit    = base_ok ? {baseline, 2'b00} : LW'(NOBASE_WAIT);
  assign at_limit = ({2'b00, cnt} >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; armed <= 1'b0; stalled <= 1'b0;
      per_done <= 1'b0; per_val <= '0; stop_pulse <= 1'b0;
    end else begin
      per_done   <= 1'b0;
      stop_pulse <= 1'b0;
      if (rise) begin
        cnt     <= {{(CNT_W-1){1'b0}}, 1'b1};
        stalled <= 1'b0;
        armed   <= 1'b1;
        if (armed) begin
          per_done <= 1'b1;
          per_val  <= cnt;
        end
      end else begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        if (at_limit && !stalled) begin
          stop_pulse <= 1'b1;
          stalled    <= 1'b1;
        end
      end
      if (restart) armed <= 1'b0;
    end
  end

  // R9: a measured period is never empty
  a_r9_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    per_done |-> (per_val != '0));
  // R4: a stop report is not repeated on the following cycle
  a_r4_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);
endmodule

// File: rtl/frw_drift_judge.sv
module frw_drift_judge #(
  parameter int CNT_W     = 16,
  parameter int TOL_SHIFT = 4,
  parameter int RUN_LEN   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_done,
  input  logic [CNT_W-1:0] per_val,
  input  logic             stop_pulse,
  output logic [CNT_W-1:0] baseline,
  output logic             base_ok,
  output logic             ireset
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);

  logic [CNT_W-1:0] diff;
  logic             off;
  logic [RW-1:0]    run;

  assign diff = (per_val >= baseline) ? (per_val - baseline) : (baseline - per_val);
  assign off  = diff > (baseline >> TOL_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseline <= '0; base_ok <= 1'b0; run <= '0; ireset <= 1'b0;
    end else begin
      ireset <= 1'b0;
      if (stop_pulse) begin
        ireset <= 1'b1; base_ok <= 1'b0; run <= '0;
      end else if (per_done) begin
        if (!base_ok) begin
          baseline <= per_val; base_ok <= 1'b1; run <= '0;
        end else if (off) begin
          if (run == RUN_LAST) begin
            ireset <= 1'b1; base_ok <= 1'b0; run <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          run <= '0;
        end
      end
    end
  end

  a_r4_stop_resets: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> ireset);
  a_r3_run_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_LAST);
  a_r1_baseline_held: assert property (@(posedge clk) disable iff (!rst_n)
    (base_ok && $past(base_ok)) |-> $stable(baseline));
  a_r5_baseline_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ireset |-> !base_ok);
endmodule

// File: rtl/frw_recovery.sv
module frw_recovery
  import frw_pkg::*;
#(
  parameter int RECOVER = 162
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ireset,
  input  logic in_strobe,
  input  logic out_strobe,
  output logic force_low
);
  localparam int CW = $clog2(RECOVER + 1);
  localparam logic [CW-1:0] REC_C = CW'(RECOVER);

  logic [CW-1:0] in_n, out_n;
  phase_e        phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_n <= '0; out_n <= '0; phase <= PH_RECOVER;
    end else if (ireset) begin
      in_n <= '0; out_n <= '0; phase <= PH_RECOVER;
    end else begin
      if (in_strobe  && in_n  != REC_C) in_n  <= in_n  + 1'b1;
      if (out_strobe && out_n != REC_C) out_n <= out_n + 1'b1;
      if (in_n == REC_C && out_n == REC_C) phase <= PH_RUN;
    end
  end

  assign force_low = (phase == PH_RECOVER);

  a_r5_force_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ireset |=> force_low);
  a_r6_release_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_low) |-> ($past(in_n) == REC_C && $past(out_n) == REC_C));
endmodule

// File: rtl/frame_rate_watch.sv
module frame_rate_watch #(
  parameter int CNT_W       = 16,
  parameter int TOL_SHIFT   = 4,
  parameter int RUN_LEN     = 8,
  parameter int RECOVER     = 162,
  parameter int NOBASE_WAIT = 4096
) (
  input  logic clk_ref,
  input  logic pdn_n,
  input  logic frame_in,
  input  logic out_strobe,
  output logic int_reset,
  output logic redetect,
  output logic force_low,
  output logic valid
);
  logic             rise, per_done, stop_pulse, base_ok, ireset;
  logic [CNT_W-1:0] per_val, baseline;

  frw_sync u_sync (.clk(clk_ref), .rst_n(pdn_n), .async_in(frame_in), .rise(rise));

  frw_period_meter #(.CNT_W(CNT_W), .NOBASE_WAIT(NOBASE_WAIT)) u_meter (
    .clk(clk_ref), .rst_n(pdn_n), .rise(rise), .restart(ireset),
    .base_ok(base_ok), .baseline(baseline),
    .per_done(per_done), .per_val(per_val), .stop_pulse(stop_pulse));

  frw_drift_judge #(.CNT_W(CNT_W), .TOL_SHIFT(TOL_SHIFT), .RUN_LEN(RUN_LEN)) u_judge (
    .clk(clk_ref), .rst_n(pdn_n), .per_done(per_done), .per_val(per_val),
    .stop_pulse(stop_pulse), .baseline(baseline), .base_ok(base_ok), .ireset(ireset));

  frw_recovery #(.RECOVER(RECOVER)) u_recov (
    .clk(clk_ref), .rst_n(pdn_n), .ireset(ireset), .in_strobe(rise),
    .out_strobe(out_strobe), .force_low(force_low));

  assign int_reset = ireset;
  assign redetect  = !base_ok;
  assign valid     = !force_low;

  // R7: power-down holds every output in its cleared state
  a_r7_powerdown_clear: assert property (@(posedge clk_ref)
    !pdn_n |-> (!int_reset && redetect && force_low && !valid));
endmodule

// File: tb/frame_rate_watch_bench.sv
module frame_rate_watch_bench;
  logic clk = 1'b0;
  logic pdn_n = 1'b0, frame_in = 1'b0, out_strobe = 1'b0;
  logic int_reset, redetect, force_low, valid;
  logic out_en = 1'b0;
  int   n_run = 0, n_fail = 0;
  string exp_q[$];

  always #2.5 clk = ~clk;

  frame_rate_watch u_frame_rate_watch (
    .clk_ref(clk), .pdn_n(pdn_n), .frame_in(frame_in), .out_strobe(out_strobe),
    .int_reset(int_reset), .redetect(redetect), .force_low(force_low), .valid(valid));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic frames(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_in = 1'b1;
      repeat (per/2 - 1) @(negedge clk);
      @(negedge clk) frame_in = 1'b0;
      repeat (per - per/2 - 1) @(negedge clk);
    end
  endtask

  task automatic expect_reset(input string tag);
    exp_q.push_back(tag);
  endtask

  // out_strobe generator: one pulse every 48 cycles while enabled
  initial forever begin
    repeat (47) @(negedge clk);
    if (out_en) out_strobe = 1'b1;
    @(negedge clk) out_strobe = 1'b0;
  end

  // monitor: every int_reset pulse must match a queued expectation
  initial forever begin
    @(negedge clk);
    if (int_reset) begin
      if (exp_q.size() == 0) chk(1'b0, "R3/R4", "unexpected int_reset", 1, 0);
      else begin
        string t;
        t = exp_q.pop_front();
        chk(1'b1, t, "int_reset matched", 1, 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R7 reset state
    chk(int_reset == 0 && redetect == 1 && force_low == 1 && valid == 0,
        "R7", "power-down outputs", {int_reset, redetect, force_low, valid}, 4'b0110);
    @(negedge clk) pdn_n = 1'b1;
    out_en = 1'b1;
    // R6/R1: start-up recovery at 64-cycle frames
    frames(2, 64);
    chk(redetect == 0, "R1", "baseline learned", redetect, 0);
    frames(159, 64);
    chk(force_low == 1, "R6", "force_low after 161 frames", force_low, 1);
    frames(1, 64);
    chk(force_low == 0 && valid == 1, "R6", "released after 162 frames", valid, 1);
    // R3: seven deviating periods then in tolerance -> no reset
    frames(7, 80);
    frames(4, 64);
    chk(valid == 1 && exp_q.size() == 0, "R3", "seven deviations ignored", valid, 1);
    // R2: 68 against baseline 64 is within tolerance, even for ten frames
    frames(10, 68);
    frames(2, 64);
    chk(valid == 1, "R2", "period 68 within tolerance", valid, 1);
    // R3/R5: eight deviating periods -> reset
    out_en = 1'b0;
    repeat (60) @(negedge clk);
    expect_reset("R3");
    frames(8, 80);
    frames(1, 80);
    chk(exp_q.size() == 0, "R3", "reset after eighth deviation", exp_q.size(), 0);
    chk(force_low == 1 && valid == 0, "R5", "forced low after reset", force_low, 1);
    chk(redetect == 1, "R1", "redetect after reset", redetect, 1);
    // R8: no output strobes -> stays forced
    frames(170, 80);
    chk(force_low == 1, "R8", "slower strobe holds force_low", force_low, 1);
    chk(redetect == 0, "R1", "baseline relearned", redetect, 0);
    out_en = 1'b1;
    frames(120, 80);
    chk(valid == 1, "R6", "released after 162 output strobes", valid, 1);
    // R4: stop frames; limit 4*80 = 320 cycles from last rise
    expect_reset("R4");
    frames(1, 80);
    repeat (200) @(negedge clk);
    chk(exp_q.size() == 1, "R4", "no reset before timeout", exp_q.size(), 1);
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "reset after frame stop", exp_q.size(), 0);
    chk(force_low == 1, "R5", "forced low after stop", force_low, 1);
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "no repeated stop reset", exp_q.size(), 0);
    // R7: power-down mid-run
    frames(4, 64);
    @(negedge clk) pdn_n = 1'b0;
    @(negedge clk);
    chk(int_reset == 0 && redetect == 1 && force_low == 1 && valid == 0,
        "R7", "power-down clears", {int_reset, redetect, force_low, valid}, 4'b0110);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule